// File: doc/BRIEF.md
# Buffered-Load Parallel-to-Serial Shifter

This block takes a parallel word into a holding (capture) register on one strobe and moves it into a chain of shift stages that emit it one bit at a time on a second strobe, most significant bit first. The move from the holding register into the shift stages is a level-driven load. It acts only while the shift strobe is low. While the shift strobe is high, the load is locked out. An active-low clear empties the shift stages without waiting for any strobe.

All four control inputs are asynchronous to the block. Each one passes through a synchroniser into a single free-running system clock. Strobe rising edges are detected inside the block, so every control takes effect a fixed number of system clock edges after it changes. The parallel word and the serial input are sampled directly. They must be held stable around the strobe that uses them.

A capture edge that arrives while a load is active sends the new parallel word straight into the shift stages in the same update. If load and clear are asserted together, the combination is illegal. The block gives clear priority and raises an error flag for as long as the combination lasts.

Top module: `bufload_serializer`

## Requirements
- R1: A rising edge of `cap_stb` stores `par_in` in the capture register, whatever the levels of `sh_stb`, `load_n` and `clear_n`.
- R2: While `load_n` is 0, `sh_stb` is 0 and `clear_n` is 1, the shift stages continuously take the capture register contents (level load, no edge needed).
- R3: A `cap_stb` rising edge during an active load (R2 conditions) puts the new `par_in` into the shift stages in the same system clock update that stores it in the capture register.
- R4: While `sh_stb` is 1, `load_n` = 0 has no effect on the shift stages.
- R5: `clear_n` = 0 with `load_n` = 1 sets every shift stage to 0 without any strobe edge.
- R6: Each rising edge of `sh_stb` with `load_n` and `clear_n` both 1 moves stage i into stage i+1 and loads `ser_in` into stage 0. A strobe held high shifts exactly once.
- R7: `ser_out` is the last stage (index WIDTH-1), so after a load `par_in[WIDTH-1]` appears first, followed by the lower bits in descending order.
- R8: `load_n` = 0 together with `clear_n` = 0 clears the stages and drives `illegal` to 1 while the combination lasts. `illegal` is 0 otherwise.
- R9: After `rst_n` is released, the capture register and the shift stages hold 0, and both `ser_out` and `illegal` are 0.
- R10: A change on a control input is reflected at the outputs on the third system clock rising edge after it is applied (two synchroniser stages plus one update), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | WIDTH | Parallel word sampled by a capture edge |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| cap_stb | input | 1 | Capture strobe, rising edge active |
| sh_stb | input | 1 | Shift strobe, rising edge shifts, high level locks out load |
| load_n | input | 1 | Active-low level load from the capture register |
| clear_n | input | 1 | Active-low clear of the shift stages |
| ser_out | output | 1 | Last shift stage |
| illegal | output | 1 | High while load and clear are both asserted |

## Verification
Two functions can act in the same system clock update: a capture edge and an active level load. The bench holds `load_n` low with `sh_stb` low so the stages track the capture register. It then raises `cap_stb` with a new word whose top bit differs from the old one and samples `ser_out` exactly on the third edge after the strobe. The new top bit must already be present there, not one cycle later. Load and clear overlapping is the second collision. It is judged by `illegal` being high and the stages reading zero, followed by a clean reload once clear is released.

// File: rtl/bls_pkg.sv
package bls_pkg;
   // Action applied to the shift stages on the next system clock edge
   typedef enum logic [1:0] {
      STG_HOLD  = 2'd0,
      STG_CLEAR = 2'd1,
      STG_LOAD  = 2'd2,
      STG_SHIFT = 2'd3
   } stg_act_t;
endpackage

// File: rtl/bls_sync.sv
module bls_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
   import bls_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cap_lvl,
   input  logic     sh_lvl,
   input  logic     ld_n_lvl,
   input  logic     clr_n_lvl,
   output logic     cap_rise,
   output logic     sh_rise,
   output stg_act_t act,
   output logic     bypass,
   output logic     err
);
   logic cap_prev, sh_prev;

   // Stored strobe levels start low so reset never fabricates an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_prev <= 1'b0;
         sh_prev  <= 1'b0;
         err      <= 1'b0;
      end else begin
         cap_prev <= cap_lvl;
         sh_prev  <= sh_lvl;
         err      <= ~clr_n_lvl & ~ld_n_lvl;
      end
   end

   assign cap_rise = cap_lvl & ~cap_prev;
   assign sh_rise  = sh_lvl & ~sh_prev;
   assign bypass   = cap_rise;

   // Priority: clear, then level load (strobe low), then shift edge
   always_comb begin
      if (!clr_n_lvl)                 act = STG_CLEAR;
      else if (!ld_n_lvl && !sh_lvl)  act = STG_LOAD;
      else if (ld_n_lvl && sh_rise)   act = STG_SHIFT;
      else                            act = STG_HOLD;
   end
endmodule

// File: rtl/bls_capture.sv
module bls_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_rise,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_q <= '0;
      else if (cap_rise) cap_q <= din;
   end
endmodule

// File: rtl/bls_shift.sv
module bls_shift
   import bls_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stg_act_t         act,
   input  logic             bypass,
   input  logic [WIDTH-1:0] cap_q,
   input  logic [WIDTH-1:0] din,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stages
);
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] load_src;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign shifted[i] = ser_in;
         end else begin : g_body
            assign shifted[i] = stages[i-1];
         end
      end
   endgenerate

   // Fresh capture data overtakes the holding register in the same update
   assign load_src = bypass ? din : cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= '0;
      else begin
         unique case (act)
            STG_CLEAR: stages <= '0;
            STG_LOAD:  stages <= load_src;
            STG_SHIFT: stages <= shifted;
            default:   stages <= stages;
         endcase
      end
   end
endmodule

// File: rtl/bufload_serializer.sv
module bufload_serializer
   import bls_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             cap_stb,
   input  logic             sh_stb,
   input  logic             load_n,
   input  logic             clear_n,
   output logic             ser_out,
   output logic             illegal
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bufload_serializer: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bufload_serializer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic cap_s, sh_s, ld_n_s, clr_n_s;
   logic cap_rise, sh_rise, bypass;
   stg_act_t act;
   logic [WIDTH-1:0] cap_q;
   logic [WIDTH-1:0] stages;

   bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cap (
      .clk(clk), .rst_n(rst_n), .d(cap_stb), .q(cap_s));
   bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sh (
      .clk(clk), .rst_n(rst_n), .d(sh_stb), .q(sh_s));
   bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst_n(rst_n), .d(load_n), .q(ld_n_s));
   bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
      .clk(clk), .rst_n(rst_n), .d(clear_n), .q(clr_n_s));

   bls_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cap_lvl(cap_s), .sh_lvl(sh_s), .ld_n_lvl(ld_n_s), .clr_n_lvl(clr_n_s),
      .cap_rise(cap_rise), .sh_rise(sh_rise), .act(act),
      .bypass(bypass), .err(illegal));

   bls_capture #(.WIDTH(WIDTH)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_rise(cap_rise), .din(par_in), .cap_q(cap_q));

   bls_shift #(.WIDTH(WIDTH)) u_shift (
      .clk(clk), .rst_n(rst_n), .act(act), .bypass(bypass),
      .cap_q(cap_q), .din(par_in), .ser_in(ser_in), .stages(stages));

   assign ser_out = stages[MSB];
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_s,
   input logic             ld_s,
   input logic             sh_s,
   input logic             sh_rise,
   input logic             cap_rise,
   input logic [WIDTH-1:0] stages,
   input logic [WIDTH-1:0] cap_q,
   input logic [WIDTH-1:0] din,
   input logic             ser_in,
   input logic             err
);
   assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_rise |=> cap_q == $past(din));

   assert_level_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && !ld_s && !sh_s && !cap_rise) |=> stages == $past(cap_q));

   assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && !ld_s && !sh_s && cap_rise) |=> (stages == $past(din)) && (stages == cap_q));

   assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && sh_s && !sh_rise) |=> $stable(stages));

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> stages == '0);

   assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && ld_s && sh_rise) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

   assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> stages == '0);
endmodule

bind bufload_serializer bls_checker #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_s(clr_n_s), .ld_s(ld_n_s), .sh_s(sh_s),
   .sh_rise(sh_rise), .cap_rise(cap_rise), .stages(stages), .cap_q(cap_q),
   .din(par_in), .ser_in(ser_in), .err(illegal));

// File: tb/sim_bufload_serializer.sv
module sim_bufload_serializer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] par_in = '0;
   logic       ser_in = 1'b0;
   logic       cap_stb = 1'b0;
   logic       sh_stb = 1'b0;
   logic       load_n = 1'b1;
   logic       clear_n = 1'b1;
   logic       ser_out;
   logic       illegal;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   bufload_serializer #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
      .cap_stb(cap_stb), .sh_stb(sh_stb), .load_n(load_n), .clear_n(clear_n),
      .ser_out(ser_out), .illegal(illegal));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_cap(input logic [7:0] d);
      par_in = d; cap_stb = 1'b1; settle();
      cap_stb = 1'b0; settle();
   endtask

   task automatic pulse_sh(input logic b);
      ser_in = b; sh_stb = 1'b1; settle();
      sh_stb = 1'b0; settle();
   endtask

   task automatic do_load();
      load_n = 1'b0; settle();
      load_n = 1'b1; settle();
   endtask

   // Shift the stages out MSB first, checking each bit (R7), feeding zeros
   task automatic readout(input string req, input logic [7:0] exp);
      for (int i = 7; i >= 0; i--) begin
         chk(req, {7'd0, ser_out}, {7'd0, exp[i]});
         pulse_sh(1'b0);
      end
   endtask

   task automatic t_reset();
      chk("R9 ser_out", {7'd0, ser_out}, 8'd0);
      chk("R9 illegal", {7'd0, illegal}, 8'd0);
      do_load();
      readout("R9 capture cleared", 8'h00);
   endtask

   task automatic t_load_basic();
      pulse_cap(8'hA5);
      do_load();
      readout("R2 R7 load A5", 8'hA5);
   endtask

   task automatic t_shift_in();
      logic [7:0] pat = 8'h3C;
      do_load();
      for (int i = 7; i >= 0; i--) begin
         chk("R7 R6 old bits out", {7'd0, ser_out}, {7'd0, 8'hA5 >> i & 8'h01});
         pulse_sh(pat[i]);
      end
      readout("R6 serial in 3C", 8'h3C);
   endtask

   task automatic t_edge_only();
      pulse_cap(8'h81);
      do_load();
      ser_in = 1'b1; sh_stb = 1'b1;
      repeat (12) @(negedge clk);
      sh_stb = 1'b0; settle();
      readout("R6 single shift per edge", 8'h03);
   endtask

   task automatic t_ignore_load();
      pulse_cap(8'h0F);
      do_load();
      pulse_cap(8'hF0);
      ser_in = 1'b0; sh_stb = 1'b1; settle();
      load_n = 1'b0; settle();
      chk("R4 load ignored while strobe high", {7'd0, ser_out}, 8'd0);
      load_n = 1'b1; settle();
      sh_stb = 1'b0; settle();
      readout("R4 contents kept", 8'h1E);
   endtask

   task automatic t_passthru();
      pulse_cap(8'hF0);
      load_n = 1'b0; settle();
      chk("R2 tracks capture", {7'd0, ser_out}, 8'd1);
      par_in = 8'h5A; cap_stb = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 R3 not before third edge", {7'd0, ser_out}, 8'd1);
      @(negedge clk);
      chk("R3 new word in same update", {7'd0, ser_out}, 8'd0);
      settle(); cap_stb = 1'b0; settle();
      load_n = 1'b1; settle();
      readout("R3 passthrough word", 8'h5A);
   endtask

   task automatic t_clear();
      pulse_cap(8'hFF);
      do_load();
      clear_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 clear not yet", {7'd0, ser_out}, 8'd1);
      @(negedge clk);
      chk("R5 clear without strobe", {7'd0, ser_out}, 8'd0);
      chk("R8 no flag for plain clear", {7'd0, illegal}, 8'd0);
      clear_n = 1'b1; settle();
      readout("R5 all stages zero", 8'h00);
   endtask

   task automatic t_illegal();
      pulse_cap(8'hC3);
      load_n = 1'b0; settle();
      clear_n = 1'b0; settle();
      chk("R8 flag raised", {7'd0, illegal}, 8'd1);
      chk("R8 clear wins", {7'd0, ser_out}, 8'd0);
      clear_n = 1'b1; settle();
      chk("R8 flag dropped", {7'd0, illegal}, 8'd0);
      load_n = 1'b1; settle();
      readout("R8 reload after illegal", 8'hC3);
   endtask

   task automatic t_capture_any();
      clear_n = 1'b0; sh_stb = 1'b1; settle();
      pulse_cap(8'h66);
      clear_n = 1'b1; settle();
      sh_stb = 1'b0; settle();
      do_load();
      readout("R1 capture under other controls", 8'h66);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_load_basic();
      t_shift_in();
      t_edge_only();
      t_ignore_load();
      t_passthru();
      t_clear();
      t_illegal();
      t_capture_any();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule